// File: doc/BRIEF.md
# Supply Supervisor and Reset Sequencer

This block watches three supply comparators and turns them into the supply-state controls of a battery-backed controller. Each comparator reports that the supply sits below one threshold: the warning level, the minimum operating level or the battery-switch level. The block ranks these into four tiers: normal, warning, reset and battery. A combination of inputs that breaks the natural nesting is treated as the most severe tier it contains. In the warning tier, a running processor receives an interrupt request and carries on executing. In the reset tier, the processor is held in reset, the bus strobes are forced inactive and the shared open-drain reset line is pulled low. In the battery tier, a power-fail flag also goes low. After the supply recovers, reset is released only once a power-on delay has run out.

The shared reset line is sensed as well as driven, so a low level put on it by another device also resets this block. An active-high external reset input has the same effect, and it also pulls the line low. A program-load pin, active low, is qualified symmetrically: it becomes active only after a run of consecutive low clocks and inactive only after the same run of high clocks. A qualified falling edge seen while running produces a one-cycle loader request. If the pin is already qualified low when reset is released, the request is issued in the release cycle.

A sequencer with four states carries the behaviour. ST_OFF is the battery tier. ST_HOLD is reset while a cause is present. ST_DELAY counts the power-on delay. ST_RUN is normal execution. The transitions are:
- T_BATT: any state goes to ST_OFF while the tier is battery.
- T_UP: ST_OFF goes to ST_HOLD when the tier drops below battery.
- T_CAUSE: ST_RUN or ST_DELAY goes to ST_HOLD on a reset cause or a sensed low on the line.
- T_CLEAR: ST_HOLD goes to ST_DELAY when no cause remains and the line is sensed high.
- T_DONE: ST_DELAY goes to ST_RUN when the delay count completes.

Every external input passes through a two-flop synchroniser.

Top module: `pwr_supervisor`

## Requirements
- R1: The tier is battery when the battery comparator is 1. Otherwise it is reset when the minimum comparator is 1, otherwise warning when the warning comparator is 1, otherwise normal. Each comparator input reads 1 when the supply is below its level.
- R2: From ST_RUN, a minimum-level drop applied before clock edge k is followed, after edge k+2, by cpu_reset=1, bus_off=1 and rst_line_pull=1. After edge k+1 all three are still 0.
- R3: A low on rst_line_in applied before edge k gives cpu_reset=1 after edge k+2. The block does not itself pull the line (rst_line_pull=0) when this external low is the only cause.
- R4: ext_reset=1 forces reset with the same three-edge latency as R2, and it pulls the line low.
- R5: pf_n is 0 exactly when the tier is battery, three edges after the inputs change.
- R6: ST_DELAY lasts POR_CLKS cycles. When an internal cause clears before edge k, cpu_reset falls after edge k+POR_CLKS+4. When only an external line low clears, cpu_reset falls after edge k+POR_CLKS+2.
- R7: warn_irq rises three edges after the warning tier appears in ST_RUN with warn_int_en=1. It stays high until a warn_clr cycle, and it is not raised again until the tier has returned to normal. With warn_int_en=0 it stays 0. Setting the enable while the warning tier persists and the request is armed raises it after the next edge. It is 0 in every non-running state.
- R8: The load pin becomes active only after PROG_QUAL_CLKS consecutive synchronised low clocks, and inactive only after the same number of high clocks. Shorter runs have no effect.
- R9: A qualified falling edge in ST_RUN gives load_entry=1 for exactly one cycle. For a pin that goes low before edge k, this cycle follows edge k+PROG_QUAL_CLKS+2.
- R10: If the load pin is qualified low when ST_DELAY ends, load_entry=1 in the first cycle with cpu_reset=0. If the pin is high, load_entry stays 0.
- R11: While rst_n=0 the block sits in ST_OFF: cpu_reset=1, bus_off=1, pf_n=0, rst_line_pull=1, warn_irq=0 and load_entry=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Battery-domain reset of the block's registers, active low |
| ext_reset | input | 1 | External reset request, active high |
| below_warn | input | 1 | Supply below warning level |
| below_min | input | 1 | Supply below minimum operating level |
| below_batt | input | 1 | Supply below battery-switch level |
| warn_int_en | input | 1 | Warning interrupt enable from the CPU |
| warn_clr | input | 1 | One-cycle clear strobe for warn_irq |
| rst_line_in | input | 1 | Sensed level of the shared reset line |
| prog_pin_n | input | 1 | Program-load pin, active low |
| rst_line_pull | output | 1 | 1 pulls the shared reset line low |
| cpu_reset | output | 1 | Internal processor reset |
| bus_off | output | 1 | 1 forces chip enables and the read/write strobe inactive |
| pf_n | output | 1 | 0 while running from battery |
| warn_irq | output | 1 | Power-fail warning interrupt request (vector 2Bh) |
| load_entry | output | 1 | One-cycle loader entry request |

## Verification
The hardest situation to reach is the exit from ST_HOLD. The block must tell its own pull on the reset line apart from a pull by another device, and then measure a power-on delay whose length depends on the synchroniser round trip through the line. The bench models the open-drain wire as the AND of the block's release and a second, bench-driven puller. This lets it release an internal cause and an external pull separately and count the exact edges to reset release in each case. Glitches on the load pin are swept over every run length around the qualification count. A separate power-up pass holds the pin low through reset to reach the release-cycle loader entry.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
    typedef enum logic [1:0] {
        T_NORM = 2'd0,
        T_WARN = 2'd1,
        T_RST  = 2'd2,
        T_BATT = 2'd3
    } tier_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DELAY = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwr_sup_sync.sv
module pwr_sup_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pwr_sup_tier.sv
module pwr_sup_tier
    import pwr_sup_pkg::*;
(
    input  logic  warn_s,
    input  logic  min_s,
    input  logic  batt_s,
    output tier_t tier
);
    always_comb begin
        if (batt_s)      tier = T_BATT;
        else if (min_s)  tier = T_RST;
        else if (warn_s) tier = T_WARN;
        else             tier = T_NORM;
    end
endmodule

// File: rtl/pwr_sup_pinqual.sv
module pwr_sup_pinqual #(
    parameter int QUAL_CLKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_s,
    output logic active,
    output logic act_pulse
);
    localparam int QW = (QUAL_CLKS > 2) ? $clog2(QUAL_CLKS) : 1;
    localparam logic [QW-1:0] QLAST = QW'(QUAL_CLKS - 1);

    logic [QW-1:0] cnt;
    logic          mismatch;

    // pin low (0) while inactive (0), or pin high (1) while active (1)
    assign mismatch = (pin_n_s == active);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            act_pulse <= 1'b0;
            cnt       <= '0;
        end else if (mismatch) begin
            if (cnt == QLAST) begin
                active    <= ~active;
                act_pulse <= ~active;
                cnt       <= '0;
            end else begin
                act_pulse <= 1'b0;
                cnt       <= cnt + 1'b1;
            end
        end else begin
            act_pulse <= 1'b0;
            cnt       <= '0;
        end
    end

    assert_qual_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(cnt) == QLAST);
endmodule

// File: rtl/pwr_sup_seq.sv
module pwr_sup_seq
    import pwr_sup_pkg::*;
#(
    parameter int POR_CLKS = 21504
) (
    input  logic  clk,
    input  logic  rst_n,
    input  tier_t tier,
    input  logic  ext_s,
    input  logic  line_hi_s,
    input  logic  warn_en,
    input  logic  warn_clr,
    input  logic  qual_active,
    input  logic  qual_pulse,
    output logic  cpu_reset,
    output logic  bus_off,
    output logic  pf_n,
    output logic  line_pull,
    output logic  warn_irq,
    output logic  load_entry
);
    localparam int CW = (POR_CLKS > 2) ? $clog2(POR_CLKS) : 1;
    localparam logic [CW-1:0] PLAST = CW'(POR_CLKS - 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic          cause;
    logic          armed;
    logic          fire;

    assign cause = (tier == T_RST) || (tier == T_BATT) || ext_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (tier != T_BATT) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (tier == T_BATT)           nxt = ST_OFF;
                else if (!cause && line_hi_s) nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (tier == T_BATT)            nxt = ST_OFF;
                else if (cause || !line_hi_s)  nxt = ST_HOLD;
                else if (cnt == PLAST)         nxt = ST_RUN;
            end
            ST_RUN: begin
                if (tier == T_BATT)           nxt = ST_OFF;
                else if (cause || !line_hi_s) nxt = ST_HOLD;
            end
        endcase
    end

    assign fire = (state == ST_RUN) && (nxt == ST_RUN) && (tier == T_WARN)
                  && warn_en && armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            cnt        <= '0;
            armed      <= 1'b1;
            warn_irq   <= 1'b0;
            load_entry <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_DELAY && nxt == ST_DELAY) ? cnt + 1'b1 : '0;
            if (fire)                armed <= 1'b0;
            else if (tier == T_NORM) armed <= 1'b1;
            if (nxt != ST_RUN)       warn_irq <= 1'b0;
            else if (fire)           warn_irq <= 1'b1;
            else if (warn_clr)       warn_irq <= 1'b0;
            load_entry <= ((state == ST_DELAY) && (nxt == ST_RUN) && qual_active)
                       || ((state == ST_RUN) && (nxt == ST_RUN) && qual_pulse);
        end
    end

    always_comb begin
        cpu_reset = (state != ST_RUN);
        bus_off   = (state != ST_RUN);
        pf_n      = (state != ST_OFF);
        line_pull = (state == ST_OFF) || ((state == ST_HOLD) && cause);
    end

    assert_reset_on_low_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tier == T_RST) |=> cpu_reset);
    assert_batt_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tier == T_BATT) |=> !pf_n);
    assert_por_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> ($past(state) == ST_DELAY && $past(cnt) == PLAST));
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_irq) |-> $past(warn_en));
    assert_load_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_entry |-> !cpu_reset);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int POR_CLKS       = 21504,
    parameter int PROG_QUAL_CLKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_reset,
    input  logic below_warn,
    input  logic below_min,
    input  logic below_batt,
    input  logic warn_int_en,
    input  logic warn_clr,
    input  logic rst_line_in,
    input  logic prog_pin_n,
    output logic rst_line_pull,
    output logic cpu_reset,
    output logic bus_off,
    output logic pf_n,
    output logic warn_irq,
    output logic load_entry
);
    localparam int NSYNC = 6;
    // order: ext, batt, min, warn, line, prog; worst-case supply at reset
    localparam logic [NSYNC-1:0] SYNC_RST = 6'b111101;

    logic [NSYNC-1:0] raw, syn;
    tier_t            tier;
    logic             qual_active, qual_pulse;

    assign raw = {ext_reset, below_batt, below_min, below_warn, rst_line_in, prog_pin_n};

    pwr_sup_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    pwr_sup_tier u_tier (
        .warn_s(syn[2]), .min_s(syn[3]), .batt_s(syn[4]), .tier(tier)
    );

    pwr_sup_pinqual #(.QUAL_CLKS(PROG_QUAL_CLKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .pin_n_s(syn[0]),
        .active(qual_active), .act_pulse(qual_pulse)
    );

    pwr_sup_seq #(.POR_CLKS(POR_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tier(tier), .ext_s(syn[5]),
        .line_hi_s(syn[1]), .warn_en(warn_int_en), .warn_clr(warn_clr),
        .qual_active(qual_active), .qual_pulse(qual_pulse),
        .cpu_reset(cpu_reset), .bus_off(bus_off), .pf_n(pf_n),
        .line_pull(rst_line_pull), .warn_irq(warn_irq), .load_entry(load_entry)
    );
endmodule

// File: tb/pwr_supervisor_bench.sv
module pwr_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P = 40;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n, ext_reset, below_warn, below_min, below_batt;
    logic warn_int_en, warn_clr, prog_pin_n, ext_pull;
    logic rst_line_in, rst_line_pull, cpu_reset, bus_off, pf_n, warn_irq, load_entry;
    int   n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rst_line_in = ~(rst_line_pull | ext_pull);

    pwr_supervisor #(.POR_CLKS(P), .PROG_QUAL_CLKS(Q)) u_pwr_supervisor (
        .clk(clk), .rst_n(rst_n), .ext_reset(ext_reset), .below_warn(below_warn),
        .below_min(below_min), .below_batt(below_batt), .warn_int_en(warn_int_en),
        .warn_clr(warn_clr), .rst_line_in(rst_line_in), .prog_pin_n(prog_pin_n),
        .rst_line_pull(rst_line_pull), .cpu_reset(cpu_reset), .bus_off(bus_off),
        .pf_n(pf_n), .warn_irq(warn_irq), .load_entry(load_entry)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            summary();
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic go_run();
        int n = 0;
        below_warn = 0; below_min = 0; below_batt = 0;
        ext_reset = 0; ext_pull = 0;
        while (cpu_reset && n < 400) begin tick(); n++; end
        warn_clr = 1; tick(); warn_clr = 0; tick();
    endtask

    task automatic count_release(output int n);
        n = 0;
        do begin tick(); n++; end while (cpu_reset && n < 400);
    endtask

    initial begin
        int n, exp_t, pulses;
        logic [2:0] c;
        rst_n = 0; ext_reset = 0; below_warn = 1; below_min = 1; below_batt = 1;
        warn_int_en = 1; warn_clr = 0; prog_pin_n = 1; ext_pull = 0;
        tick(3);
        // R11 reset state
        chk("R11 cpu_reset", cpu_reset, 1);
        chk("R11 bus_off", bus_off, 1);
        chk("R11 pf_n", pf_n, 0);
        chk("R11 pull", rst_line_pull, 1);
        chk("R11 irq", warn_irq, 0);
        chk("R11 load", load_entry, 0);
        rst_n = 1;
        below_warn = 0; below_min = 0; below_batt = 0;
        count_release(n);
        chk("R10 no load with pin high", load_entry, 0);
        go_run();

        // R2 entry latency, R6 release after internal cause
        below_min = 1; below_warn = 1;
        tick(2);
        chk("R2 reset not yet", cpu_reset, 0);
        tick(1);
        chk("R2 cpu_reset", cpu_reset, 1);
        chk("R2 bus_off", bus_off, 1);
        chk("R2 pull", rst_line_pull, 1);
        tick(5);
        below_min = 0; below_warn = 0;
        count_release(n);
        chk("R6 release edges after min", n, P + 5);
        go_run();

        // R3 external line pull
        ext_pull = 1;
        tick(2);
        chk("R3 reset not yet", cpu_reset, 0);
        tick(1);
        chk("R3 cpu_reset", cpu_reset, 1);
        chk("R3 no self pull", rst_line_pull, 0);
        tick(5);
        ext_pull = 0;
        count_release(n);
        chk("R6 R3 release edges after line", n, P + 3);
        go_run();

        // R4 external reset input
        ext_reset = 1;
        tick(2);
        chk("R4 reset not yet", cpu_reset, 0);
        tick(1);
        chk("R4 cpu_reset", cpu_reset, 1);
        chk("R4 pull", rst_line_pull, 1);
        tick(4);
        ext_reset = 0;
        count_release(n);
        chk("R4 release edges", n, P + 5);
        go_run();

        // R1 R5 exhaustive comparator sweep
        for (int k = 0; k < 8; k++) begin
            c = 3'(k);
            go_run();
            below_batt = c[2]; below_min = c[1]; below_warn = c[0];
            tick(3);
            exp_t = c[2] ? 3 : c[1] ? 2 : c[0] ? 1 : 0;
            chk($sformatf("R1 cpu_reset c=%0d", k), cpu_reset, int'(exp_t >= 2));
            chk($sformatf("R1 pull c=%0d", k), rst_line_pull, int'(exp_t >= 2));
            chk($sformatf("R5 pf_n c=%0d", k), pf_n, int'(exp_t != 3));
            chk($sformatf("R1 R7 irq c=%0d", k), warn_irq, int'(exp_t == 1));
        end
        go_run();

        // R7 warning request behaviour
        below_warn = 1;
        tick(2);
        chk("R7 irq not yet", warn_irq, 0);
        tick(1);
        chk("R7 irq raised", warn_irq, 1);
        tick(10);
        chk("R7 irq held", warn_irq, 1);
        warn_clr = 1; tick(); warn_clr = 0;
        chk("R7 irq cleared", warn_irq, 0);
        tick(10);
        chk("R7 no rearm while warning", warn_irq, 0);
        below_warn = 0; tick(5);
        below_warn = 1; tick(3);
        chk("R7 rearmed irq", warn_irq, 1);
        warn_clr = 1; tick(); warn_clr = 0;
        below_warn = 0; warn_int_en = 0; tick(5);
        below_warn = 1; tick(6);
        chk("R7 disabled irq", warn_irq, 0);
        warn_int_en = 1; tick(1);
        chk("R7 enable fires", warn_irq, 1);
        go_run();

        // R9 exact load timing, R8 symmetric qualification
        prog_pin_n = 0;
        tick(Q + 2);
        chk("R9 load not yet", load_entry, 0);
        tick(1);
        chk("R9 load pulse", load_entry, 1);
        tick(1);
        chk("R9 load one cycle", load_entry, 0);
        prog_pin_n = 1; tick(Q - 1);
        prog_pin_n = 0;
        pulses = 0;
        for (int i = 0; i < Q + 6; i++) begin tick(); pulses += int'(load_entry); end
        chk("R8 short high run ignored", pulses, 0);
        prog_pin_n = 1; tick(Q + 4);
        for (int len = 1; len <= Q + 1; len++) begin
            pulses = 0;
            prog_pin_n = 0;
            for (int i = 0; i < Q + 8; i++) begin
                if (i == len) prog_pin_n = 1;
                tick(); pulses += int'(load_entry);
            end
            prog_pin_n = 1; tick(Q + 4);
            chk($sformatf("R8 R9 low run %0d", len), pulses, int'(len >= Q));
        end

        // R10 power-up with load pin low
        rst_n = 0; below_warn = 1; below_min = 1; below_batt = 1;
        prog_pin_n = 0;
        tick(4);
        rst_n = 1; below_warn = 0; below_min = 0; below_batt = 0;
        count_release(n);
        chk("R10 load at release", load_entry, 1);
        tick(1);
        chk("R10 load one cycle", load_entry, 0);
        summary();
    end
endmodule